// File: doc/BRIEF.md
# Trigger-Gated Readout Capture Framer

This block sits between the readout sample processing and a set of per-channel DMA stream inputs. Each readout channel receives a continuous sample stream from two converter inputs: one single-ended, one differential. A channel stays idle until the pulse-generator channel it is bound to raises its trigger. It then turns a programmed number of valid samples into an AXI4-Stream record, and the last beat of the record carries tlast.

Each channel has its own configuration, applied at the moment the trigger is taken. The configuration selects which generator trigger it listens to, which of its two sources feeds the record, and how many beats the record holds. The channel never stalls the converter stream. A beat that the downstream side does not accept in the cycle it is offered is lost, and a sticky flag records the loss. The channel also keeps two saturating counters: one for triggers that arrived while a record was still open, and one for completed records.

Top module: `readout_framer`

## Requirements
- R1: After a synchronous reset every tvalid, tlast, overrun flag, ignored-trigger count and record count is zero.
- R2: A channel opens a record only on a pulse of the generator trigger whose index equals its trigger-select field. Pulses on any other generator trigger leave it idle and emit no beat.
- R3: A record opened with length N emits exactly N beats. tlast is high on the Nth beat only, and tvalid is low in the cycle after the tlast beat.
- R4: Source-select value 0 routes the single-ended input into the record and value 1 routes the differential input. The value is sampled in the trigger cycle, so changing it during a record has no effect on that record.
- R5: The record length is sampled in the trigger cycle, and later changes do not alter the open record. A trigger taken with length 0 opens no record and changes no counter.
- R6: A selected trigger that arrives while a record is open is ignored: the record continues unchanged and the ignored-trigger count rises by one, saturating at its all-ones value.
- R7: A beat offered with tready low is dropped and not held. The following samples keep flowing as beats, and the overrun flag sets in the next cycle and stays set until reset.
- R8: The record count rises by one for each beat emitted with tlast, saturating at its all-ones value.
- R9: Channels are independent: a trigger, record or drop on one channel leaves the outputs and counters of every other channel unchanged.
- R10: Only samples with their valid input high become beats. The first candidate sample is the one presented in the cycle after the trigger, and each beat appears one cycle after its sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_trig | input | NGEN | One trigger pulse line per generator channel |
| smp_vld | input | NCH | Per-channel sample valid |
| smp_se | input | NCH*DATA_W | Per-channel single-ended source samples |
| smp_diff | input | NCH*DATA_W | Per-channel differential source samples |
| cfg_trig_sel | input | NCH*SEL_W | Per-channel generator trigger index |
| cfg_src_diff | input | NCH | Per-channel source select (0 single-ended, 1 differential) |
| cfg_rec_len | input | NCH*LEN_W | Per-channel record length in beats |
| m_axis_tready | input | NCH | Downstream ready per channel |
| m_axis_tvalid | output | NCH | Beat valid per channel |
| m_axis_tdata | output | NCH*DATA_W | Beat data per channel |
| m_axis_tlast | output | NCH | Last beat of a record per channel |
| ign_trig_cnt | output | NCH*CNT_W | Saturating count of ignored triggers |
| overrun | output | NCH | Sticky flag for dropped beats |
| rec_cnt | output | NCH*CNT_W | Saturating count of completed records |

## Verification
Records are opened under four kinds of input pattern, and each one separates a different class of fault.

- A pulse on an unbound trigger line next to a bound one exposes trigger-index decoding faults.
- A continuous valid stream shows off-by-one errors in the length, the first-sample alignment and the position of tlast.
- An alternating valid pattern shows whether gaps are counted as beats.
- A burst of extra triggers during a long record shows whether a record restarts, truncates or fails to count the ignored trigger.

Configuration is changed immediately after the trigger to prove it is latched. A short tready dip shows that beats are dropped rather than stalled. Two channels triggered together, with different sources and lengths, show that they keep separate state.

// File: rtl/rsf_pkg.sv
package rsf_pkg;
  typedef enum logic {
    SRC_SINGLE = 1'b0,
    SRC_DIFF   = 1'b1
  } src_e;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rsf_trig_pick.sv
module rsf_trig_pick #(
  parameter int NGEN  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NGEN-1:0]  trig,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NGEN; i++) begin
      if (sel == SEL_W'(i)) hit = trig[i];
    end
  end
endmodule

// File: rtl/rsf_sat_cnt.sv
module rsf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rsf_chan.sv
module rsf_chan
  import rsf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_se,
  input  logic [DATA_W-1:0] smp_diff,
  input  logic              cfg_src,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              tready,
  output logic              tvalid,
  output logic [DATA_W-1:0] tdata,
  output logic              tlast,
  output logic [CNT_W-1:0]  ign_cnt,
  output logic              overrun,
  output logic [CNT_W-1:0]  rec_cnt
);
  localparam logic [LEN_W-1:0] ONE_LEFT = LEN_W'(1);
  localparam logic [CNT_W-1:0] CNT_TOP  = '1;

  logic             busy;
  logic [LEN_W-1:0] left;
  src_e             src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      left    <= '0;
      src_q   <= SRC_SINGLE;
      tvalid  <= 1'b0;
      tlast   <= 1'b0;
      tdata   <= '0;
      overrun <= 1'b0;
    end else begin
      tvalid <= 1'b0;
      tlast  <= 1'b0;
      if (!busy && hit && cfg_len != '0) begin
        busy  <= 1'b1;
        left  <= cfg_len;
        src_q <= src_e'(cfg_src);
      end
      if (busy && smp_vld) begin
        tvalid <= 1'b1;
        tdata  <= (src_q == SRC_DIFF) ? smp_diff : smp_se;
        tlast  <= (left == ONE_LEFT);
        left   <= left - 1'b1;
        if (left == ONE_LEFT) busy <= 1'b0;
      end
      if (tvalid && !tready) overrun <= 1'b1;
    end
  end

  rsf_sat_cnt #(.W(CNT_W)) i_ign (
    .clk(clk), .rst(rst), .inc(busy && hit), .cnt(ign_cnt)
  );

  rsf_sat_cnt #(.W(CNT_W)) i_rec (
    .clk(clk), .rst(rst), .inc(tvalid && tlast), .cnt(rec_cnt)
  );

  assert_last_has_valid_R3: assert property (@(posedge clk) disable iff (rst)
    tlast |-> tvalid);
  assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    (tvalid && tlast) |=> !tvalid);
  assert_idle_no_beat_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !tvalid);
  assert_no_beat_without_sample_R10: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> !tvalid);
  assert_ign_count_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && hit && ign_cnt != CNT_TOP) |=> ign_cnt == CNT_W'($past(ign_cnt) + 1'b1));
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (tvalid && !tready) |=> overrun);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  assert_rec_count_R8: assert property (@(posedge clk) disable iff (rst)
    (tvalid && tlast && rec_cnt != CNT_TOP) |=> rec_cnt == CNT_W'($past(rec_cnt) + 1'b1));
endmodule

// File: rtl/readout_framer.sv
module readout_framer
  import rsf_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int NGEN   = 4,
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 16,
  localparam int SEL_W = sel_width(NGEN)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NGEN-1:0]       gen_trig,
  input  logic [NCH-1:0]        smp_vld,
  input  logic [NCH*DATA_W-1:0] smp_se,
  input  logic [NCH*DATA_W-1:0] smp_diff,
  input  logic [NCH*SEL_W-1:0]  cfg_trig_sel,
  input  logic [NCH-1:0]        cfg_src_diff,
  input  logic [NCH*LEN_W-1:0]  cfg_rec_len,
  input  logic [NCH-1:0]        m_axis_tready,
  output logic [NCH-1:0]        m_axis_tvalid,
  output logic [NCH*DATA_W-1:0] m_axis_tdata,
  output logic [NCH-1:0]        m_axis_tlast,
  output logic [NCH*CNT_W-1:0]  ign_trig_cnt,
  output logic [NCH-1:0]        overrun,
  output logic [NCH*CNT_W-1:0]  rec_cnt
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;

    rsf_trig_pick #(.NGEN(NGEN), .SEL_W(SEL_W)) i_pick (
      .trig(gen_trig),
      .sel (cfg_trig_sel[c*SEL_W +: SEL_W]),
      .hit (hit)
    );

    rsf_chan #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) i_chan (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit),
      .smp_vld (smp_vld[c]),
      .smp_se  (smp_se[c*DATA_W +: DATA_W]),
      .smp_diff(smp_diff[c*DATA_W +: DATA_W]),
      .cfg_src (cfg_src_diff[c]),
      .cfg_len (cfg_rec_len[c*LEN_W +: LEN_W]),
      .tready  (m_axis_tready[c]),
      .tvalid  (m_axis_tvalid[c]),
      .tdata   (m_axis_tdata[c*DATA_W +: DATA_W]),
      .tlast   (m_axis_tlast[c]),
      .ign_cnt (ign_trig_cnt[c*CNT_W +: CNT_W]),
      .overrun (overrun[c]),
      .rec_cnt (rec_cnt[c*CNT_W +: CNT_W])
    );
  end
endmodule

// File: tb/test_readout_framer.sv
module test_readout_framer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2, NGEN = 4, DW = 16, LW = 6, CW = 3, SW = 2;

  logic clk = 0, rst = 1;
  logic [NGEN-1:0] trig = '0;
  logic [NCH-1:0] svld = '1, ssel = '0, trdy = '1;
  logic [NCH*DW-1:0] srca, srcb;
  logic [NCH*SW-1:0] tsel = '0;
  logic [NCH*LW-1:0] clen = '0;
  logic [NCH-1:0] tvalid, tlast, ovr;
  logic [NCH*DW-1:0] tdata;
  logic [NCH*CW-1:0] ign, rec;

  int seq = 0, checks = 0, fails = 0;
  logic [DW-1:0] log_d [NCH][64];
  logic          log_l [NCH][64];
  int            nb [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  readout_framer #(.NCH(NCH), .NGEN(NGEN), .DATA_W(DW), .LEN_W(LW), .CNT_W(CW)) i_readout_framer (
    .clk(clk), .rst(rst), .gen_trig(trig), .smp_vld(svld), .smp_se(srca), .smp_diff(srcb),
    .cfg_trig_sel(tsel), .cfg_src_diff(ssel), .cfg_rec_len(clen), .m_axis_tready(trdy),
    .m_axis_tvalid(tvalid), .m_axis_tdata(tdata), .m_axis_tlast(tlast),
    .ign_trig_cnt(ign), .overrun(ovr), .rec_cnt(rec)
  );

  function automatic logic [DW-1:0] expd(input int c, input int src, input int s);
    return {(src != 0) ? 4'h2 : 4'h1, 4'(c), 8'(s)};
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      srca[c*DW +: DW] = expd(c, 0, seq);
      srcb[c*DW +: DW] = expd(c, 1, seq);
    end
  end

  always @(posedge clk) begin
    #1 seq = seq + 1;
  end

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (tvalid[c] && nb[c] < 64) begin
        log_d[c][nb[c]] = tdata[c*DW +: DW];
        log_l[c][nb[c]] = tlast[c];
        nb[c] = nb[c] + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [NGEN-1:0] t, input logic [NCH-1:0] v);
    @(posedge clk);
    #2;
    trig = t;
    svld = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc('0, '1);
  endtask

  task automatic clear_logs();
    for (int c = 0; c < NCH; c++) nb[c] = 0;
  endtask

  task automatic set_ch(input int c, input int sel, input int src, input int len);
    tsel[c*SW +: SW] = SW'(sel);
    ssel[c] = 1'(src);
    clen[c*LW +: LW] = LW'(len);
  endtask

  task automatic check_rec(input int c, input int s0, input int src, input int len, input string req);
    chk(nb[c] == len, req, nb[c], len);
    for (int k = 0; k < len && k < nb[c]; k++) begin
      chk(log_d[c][k] == expd(c, src, s0 + 1 + k), req, log_d[c][k], expd(c, src, s0 + 1 + k));
      chk(log_l[c][k] == (k == len - 1), req, log_l[c][k], (k == len - 1));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(tvalid == 0 && tlast == 0, "R1", {tvalid, tlast}, 0);
    chk(ovr == 0 && ign == 0 && rec == 0, "R1", {ovr, ign, rec}, 0);
  endtask

  task automatic t_basic();
    int s0;
    set_ch(0, 2, 0, 5);
    set_ch(1, 0, 0, 3);
    clear_logs();
    cyc(4'b0010, '1);
    idle(5);
    chk(nb[0] == 0 && nb[1] == 0, "R2", nb[0] + nb[1], 0);
    clear_logs();
    cyc(4'b0100, '1);
    s0 = seq;
    idle(8);
    check_rec(0, s0, 0, 5, "R3");
    chk(nb[1] == 0, "R9", nb[1], 0);
    @(negedge clk);
    chk(rec[0 +: CW] == 1, "R8", rec[0 +: CW], 1);
    chk(rec[CW +: CW] == 0, "R9", rec[CW +: CW], 0);
  endtask

  task automatic t_latch();
    int s0;
    set_ch(0, 2, 1, 3);
    clear_logs();
    cyc(4'b0100, '1);
    s0 = seq;
    cyc('0, '1);
    set_ch(0, 2, 0, 10);
    idle(14);
    check_rec(0, s0, 1, 3, "R4 R5");
  endtask

  task automatic t_len0();
    set_ch(0, 2, 0, 0);
    clear_logs();
    cyc(4'b0100, '1);
    idle(6);
    @(negedge clk);
    chk(nb[0] == 0, "R5", nb[0], 0);
    chk(rec[0 +: CW] == 2 && ign[0 +: CW] == 0, "R5", {rec[0 +: CW], ign[0 +: CW]}, {3'd2, 3'd0});
  endtask

  task automatic t_gaps();
    int s0;
    set_ch(0, 2, 0, 4);
    clear_logs();
    cyc(4'b0100, '1);
    s0 = seq;
    for (int k = 1; k <= 8; k++) cyc('0, {1'b1, 1'((k % 2) == 0)});
    idle(4);
    chk(nb[0] == 4, "R10", nb[0], 4);
    for (int k = 0; k < 4 && k < nb[0]; k++) begin
      chk(log_d[0][k] == expd(0, 0, s0 + 2 + 2*k), "R10", log_d[0][k], expd(0, 0, s0 + 2 + 2*k));
    end
    chk(nb[0] >= 4 && log_l[0][3] == 1, "R10", 0, 1);
  endtask

  task automatic t_multi();
    int s0;
    set_ch(0, 2, 0, 3);
    set_ch(1, 3, 1, 2);
    clear_logs();
    cyc(4'b1100, '1);
    s0 = seq;
    idle(6);
    check_rec(0, s0, 0, 3, "R9");
    check_rec(1, s0, 1, 2, "R9");
  endtask

  task automatic t_ignored();
    int s0;
    set_ch(0, 2, 0, 20);
    clear_logs();
    cyc(4'b0100, '1);
    s0 = seq;
    for (int k = 0; k < 3; k++) cyc(4'b0100, '1);
    idle(24);
    check_rec(0, s0, 0, 20, "R6");
    @(negedge clk);
    chk(ign[0 +: CW] == 3, "R6", ign[0 +: CW], 3);
    chk(ign[CW +: CW] == 0, "R9", ign[CW +: CW], 0);
    cyc(4'b0100, '1);
    for (int k = 0; k < 10; k++) cyc(4'b0100, '1);
    idle(16);
    @(negedge clk);
    chk(ign[0 +: CW] == 7, "R6", ign[0 +: CW], 7);
    chk(rec[0 +: CW] == 6, "R8", rec[0 +: CW], 6);
  endtask

  task automatic t_rec_sat();
    set_ch(0, 2, 0, 1);
    for (int k = 0; k < 4; k++) begin
      cyc(4'b0100, '1);
      idle(3);
    end
    @(negedge clk);
    chk(rec[0 +: CW] == 7, "R8", rec[0 +: CW], 7);
  endtask

  task automatic t_ready();
    int s0;
    @(negedge clk);
    chk(ovr == 0, "R7", ovr, 0);
    set_ch(0, 2, 0, 6);
    clear_logs();
    cyc(4'b0100, '1);
    s0 = seq;
    idle(2);
    trdy[0] = 1'b0;
    idle(2);
    trdy[0] = 1'b1;
    idle(6);
    check_rec(0, s0, 0, 6, "R7");
    @(negedge clk);
    chk(ovr[0] == 1, "R7", ovr[0], 1);
    chk(ovr[1] == 0, "R9", ovr[1], 0);
    idle(5);
    @(negedge clk);
    chk(ovr[0] == 1, "R7", ovr[0], 1);
  endtask

  initial begin
    clear_logs();
    repeat (3) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_basic();
    t_latch();
    t_len0();
    t_gaps();
    t_multi();
    t_ignored();
    t_rec_sat();
    t_ready();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule